// File: doc/BRIEF.md
# Turn-Synchronous Bucket Sample Averager

This block measures a single bucket of a circulating beam by taking one converter sample from it on every revolution. Converter samples arrive with a valid strobe. A revolution marker shows where each turn begins. Every valid sample is given a slot index that counts from the marker. On each turn the sample whose index equals the programmed slot is taken, and added to a running sum and to a running sum of squares.

After a fixed number of turns the block reports two results:
- the mean of the captured samples;
- their population variance.

A bucket that holds a real bunch returns nearly the same value on every turn, so its variance is small. An empty bucket shows only noise, so its variance is large.

A host drives a small write port with two registers:
- a slot register, which takes values below the slot count;
- a start register, which starts a new measurement (or restarts one that is running).

The host then waits for the one-clock done pulse. The square root, any plotting and all host software are outside this block.

With the default parameters a turn has 324 sample slots, because 1296 buckets are sampled at a quarter of the bucket rate. Samples are 14-bit two's complement and each measurement covers 4096 turns. Both counts are parameters. The turn count is 2^TURNS_LOG2.

Top module: `turn_bucket_avg`

## Requirements
- R1: After reset, busy, done and slot_err are 0, and mean and variance are 0. The slot register holds 0.
- R2: A host write with host_addr=0 and data below SLOTS loads the slot register and clears slot_err.
- R3: A host write with host_addr=0 and data of SLOTS or more is rejected. slot_err becomes 1 and the slot register keeps its previous value.
- R4: Slot index 0 belongs to the valid sample in the cycle where rev_mark is high. If no valid sample comes in that cycle, index 0 belongs to the first valid sample after it. Each later valid sample adds one to the index. Cycles with adc_valid low are not counted. Samples that arrive before the first marker after reset are never captured.
- R5: A host write with host_addr=1 (any data) starts a measurement. Each turn adds the one sample whose index equals the slot register. After exactly 2^TURNS_LOG2 captured samples, busy falls and done is high for exactly one clock.
- R6: mean equals floor(S / 2^TURNS_LOG2), where S is the signed sum of the captured samples.
- R7: variance equals floor((n·Q − S²) / n²), where n = 2^TURNS_LOG2 and Q is the sum of squares. The result is 0 when every captured sample is the same, negative values included.
- R8: A marker that arrives before SLOTS valid samples have been counted starts the index again at 0. Slot indexes the short turn never reached are not captured in it.
- R9: mean and variance change only in the cycle in which done is high. They hold their values until the next measurement completes, whatever samples arrive in the meantime.
- R10: A start that arrives during a measurement throws away the partial sums. The next result covers only the turns after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_valid | input | 1 | Strobe for adc_data |
| adc_data | input | SAMPLE_W | Signed converter sample |
| rev_mark | input | 1 | Revolution marker, one cycle per turn |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = slot register, 1 = start command |
| host_wdata | input | HOST_W | Host write data |
| slot_err | output | 1 | Last slot write was out of range |
| busy | output | 1 | Measurement or result computation in progress |
| done | output | 1 | One-clock pulse, results valid |
| mean | output | SAMPLE_W | Signed mean of captured samples |
| variance | output | 2*SAMPLE_W | Unsigned population variance |

## Verification
The assertions check the following on every cycle:
- the slot register never holds an illegal index;
- a rejected write leaves the slot register unchanged;
- at most one sample is taken per turn;
- a measurement ends only on a capture;
- done never lasts two cycles;
- the term inside the variance is never negative;
- the results move only together with done.

Only the bench scenarios can show that the correct sample is chosen and that the mean and variance are right. They cover idle marker cycles, gaps in the valid strobe, short turns, samples that arrive before the first marker, extreme sample values and restarts.

// File: rtl/tba_pkg.sv
package tba_pkg;
  // Host register map
  localparam logic HADDR_SLOT  = 1'b0;
  localparam logic HADDR_START = 1'b1;

  // Result pipeline state
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MULT  = 2'd1,
    ST_FINAL = 2'd2
  } stats_state_e;
endpackage

// File: rtl/tba_host_regs.sv
module tba_host_regs #(
  parameter int SLOTS  = 324,
  parameter int HOST_W = 16,
  localparam int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  slot_o,
  output logic              err_o,
  output logic              start_o
);
  import tba_pkg::*;

  logic in_range;
  assign in_range = (wdata_i < HOST_W'(SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o  <= '0;
      err_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= wr_i && (addr_i == HADDR_START);
      if (wr_i && (addr_i == HADDR_SLOT)) begin
        if (in_range) begin
          slot_o <= wdata_i[IDX_W-1:0];
          err_o  <= 1'b0;
        end else begin
          err_o  <= 1'b1;
        end
      end
    end
  end

  p_slot_legal_r3: assert property (@(posedge clk) disable iff (rst)
    slot_o < IDX_W'(SLOTS));

  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == HADDR_SLOT && wdata_i >= HOST_W'(SLOTS))
      |=> (err_o && $stable(slot_o)));
endmodule

// File: rtl/tba_slot_track.sv
module tba_slot_track #(
  parameter int SLOTS    = 324,
  parameter int SAMPLE_W = 14,
  localparam int IDX_W   = $clog2(SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] data_i,
  input  logic                       mark_i,
  input  logic [IDX_W-1:0]           slot_i,
  output logic                       hit_o,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  // Index of the next valid sample; SLOTS means "not synchronised / past end"
  logic [IDX_W-1:0] pos_q;
  logic [IDX_W-1:0] cur_idx;
  logic             match;
  logic             seen_q;

  assign cur_idx = mark_i ? '0 : pos_q;
  assign match   = valid_i && (cur_idx < IDX_W'(SLOTS)) && (cur_idx == slot_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= IDX_W'(SLOTS);
    end else if (mark_i) begin
      pos_q <= valid_i ? IDX_W'(1) : '0;
    end else if (valid_i && (pos_q < IDX_W'(SLOTS))) begin
      pos_q <= pos_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o    <= 1'b0;
      sample_o <= '0;
    end else begin
      hit_o <= match;
      if (match) sample_o <= data_i;
    end
  end

  // Tracks whether this turn already produced a capture
  always_ff @(posedge clk) begin
    if (rst)         seen_q <= 1'b0;
    else if (mark_i) seen_q <= match;
    else if (match)  seen_q <= 1'b1;
  end

  p_one_per_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (match && !mark_i) |-> !seen_q);
endmodule

// File: rtl/tba_accum.sv
module tba_accum #(
  parameter int SAMPLE_W   = 14,
  parameter int TURNS_LOG2 = 12,
  localparam int SUM_W     = SAMPLE_W + TURNS_LOG2,
  localparam int SQ_W      = 2 * SAMPLE_W + TURNS_LOG2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       hit_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       armed_o,
  output logic                       fin_o,
  output logic signed [SUM_W-1:0]    sum_o,
  output logic [SQ_W-1:0]            sq_o
);
  logic [TURNS_LOG2-1:0]        cnt_q;
  logic signed [2*SAMPLE_W-1:0] sq_s;
  logic [2*SAMPLE_W-1:0]        sq_u;
  logic                         take;

  assign sq_s = sample_i * sample_i;
  assign sq_u = sq_s;
  assign take = armed_o && hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
      fin_o   <= 1'b0;
      cnt_q   <= '0;
      sum_o   <= '0;
      sq_o    <= '0;
    end else begin
      fin_o <= 1'b0;
      if (start_i) begin
        armed_o <= 1'b1;
        cnt_q   <= '0;
        sum_o   <= '0;
        sq_o    <= '0;
      end else if (take) begin
        sum_o <= sum_o + SUM_W'(sample_i);
        sq_o  <= sq_o + SQ_W'(sq_u);
        cnt_q <= cnt_q + TURNS_LOG2'(1);
        if (cnt_q == {TURNS_LOG2{1'b1}}) begin
          armed_o <= 1'b0;
          fin_o   <= 1'b1;
        end
      end
    end
  end

  p_end_on_capture_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(armed_o) |-> $past(hit_i));

  p_fin_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !fin_o);
endmodule

// File: rtl/tba_stats.sv
module tba_stats #(
  parameter int SAMPLE_W   = 14,
  parameter int TURNS_LOG2 = 12,
  localparam int SUM_W     = SAMPLE_W + TURNS_LOG2,
  localparam int SQ_W      = 2 * SAMPLE_W + TURNS_LOG2,
  localparam int WIDE_W    = 2 * SUM_W,
  localparam int VAR_W     = 2 * SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fin_i,
  input  logic signed [SUM_W-1:0]    sum_i,
  input  logic [SQ_W-1:0]            sq_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic signed [SAMPLE_W-1:0] mean_o,
  output logic [VAR_W-1:0]           var_o
);
  import tba_pkg::*;

  stats_state_e               st_q;
  logic signed [WIDE_W-1:0]   sum2_q;
  logic [WIDE_W-1:0]          sqn_q;
  logic signed [SAMPLE_W-1:0] mean_q;
  logic [WIDE_W-1:0]          diff;
  logic [WIDE_W-1:0]          sum2_u;

  assign sum2_u = sum2_q;
  assign diff   = sqn_q - sum2_u;
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sum2_q <= '0;
      sqn_q  <= '0;
      mean_q <= '0;
      mean_o <= '0;
      var_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fin_i) st_q <= ST_MULT;
        ST_MULT: begin
          sum2_q <= WIDE_W'(sum_i) * WIDE_W'(sum_i);
          sqn_q  <= {sq_i, {TURNS_LOG2{1'b0}}};
          mean_q <= sum_i[SUM_W-1:TURNS_LOG2];
          st_q   <= ST_FINAL;
        end
        ST_FINAL: begin
          var_o  <= diff[WIDE_W-1:2*TURNS_LOG2];
          mean_o <= mean_q;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_var_nonneg_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FINAL) |-> (sqn_q >= sum2_u));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_mean_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mean_o) |-> done_o);

  p_var_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(var_o) |-> done_o);
endmodule

// File: rtl/turn_bucket_avg.sv
module turn_bucket_avg #(
  parameter int SLOTS      = 324,
  parameter int SAMPLE_W   = 14,
  parameter int TURNS_LOG2 = 12,
  parameter int HOST_W     = 16,
  localparam int IDX_W     = $clog2(SLOTS + 1),
  localparam int SUM_W     = SAMPLE_W + TURNS_LOG2,
  localparam int SQ_W      = 2 * SAMPLE_W + TURNS_LOG2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adc_valid,
  input  logic signed [SAMPLE_W-1:0] adc_data,
  input  logic                       rev_mark,
  input  logic                       host_wr,
  input  logic                       host_addr,
  input  logic [HOST_W-1:0]          host_wdata,
  output logic                       slot_err,
  output logic                       busy,
  output logic                       done,
  output logic signed [SAMPLE_W-1:0] mean,
  output logic [2*SAMPLE_W-1:0]      variance
);
  logic [IDX_W-1:0]           slot_sel;
  logic                       start_p;
  logic                       hit;
  logic signed [SAMPLE_W-1:0] hit_sample;
  logic                       armed;
  logic                       fin;
  logic signed [SUM_W-1:0]    acc_sum;
  logic [SQ_W-1:0]            acc_sq;
  logic                       stats_busy;

  tba_host_regs #(.SLOTS(SLOTS), .HOST_W(HOST_W)) regs_i (
    .clk(clk), .rst(rst), .wr_i(host_wr), .addr_i(host_addr),
    .wdata_i(host_wdata), .slot_o(slot_sel), .err_o(slot_err),
    .start_o(start_p));

  tba_slot_track #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) track_i (
    .clk(clk), .rst(rst), .valid_i(adc_valid), .data_i(adc_data),
    .mark_i(rev_mark), .slot_i(slot_sel), .hit_o(hit),
    .sample_o(hit_sample));

  tba_accum #(.SAMPLE_W(SAMPLE_W), .TURNS_LOG2(TURNS_LOG2)) acc_i (
    .clk(clk), .rst(rst), .start_i(start_p), .hit_i(hit),
    .sample_i(hit_sample), .armed_o(armed), .fin_o(fin),
    .sum_o(acc_sum), .sq_o(acc_sq));

  tba_stats #(.SAMPLE_W(SAMPLE_W), .TURNS_LOG2(TURNS_LOG2)) stats_i (
    .clk(clk), .rst(rst), .fin_i(fin), .sum_i(acc_sum), .sq_i(acc_sq),
    .busy_o(stats_busy), .done_o(done), .mean_o(mean), .var_o(variance));

  assign busy = armed || fin || stats_busy;
endmodule

// File: tb/turn_bucket_avg_tb_top.sv
module turn_bucket_avg_tb_top;
  localparam int SLOTS = 8;
  localparam int W     = 14;
  localparam int LG    = 3;
  localparam int NT    = 1 << LG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adc_valid = 1'b0;
  logic signed [W-1:0] adc_data = '0;
  logic rev_mark = 1'b0;
  logic host_wr = 1'b0;
  logic host_addr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic slot_err, busy, done;
  logic signed [W-1:0] mean;
  logic [2*W-1:0] variance;

  always #2 clk = ~clk;

  turn_bucket_avg #(.SLOTS(SLOTS), .SAMPLE_W(W), .TURNS_LOG2(LG), .HOST_W(16)) dut_i (
    .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_data(adc_data),
    .rev_mark(rev_mark), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .slot_err(slot_err), .busy(busy), .done(done),
    .mean(mean), .variance(variance));

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int dbl_done = 0;
  bit done_prev = 0;
  int turn_no = 0;
  int cur_slot = 0;
  longint m_sum, m_sq;
  int m_cnt = 0;
  bit m_on = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (done && done_prev) dbl_done++;
      if (done) done_cnt++;
      done_prev = done;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int d, input bit m);
    adc_valid = v;
    adc_data  = W'(d);
    rev_mark  = m;
    @(negedge clk);
  endtask

  task automatic host(input bit a, input int d);
    host_wr = 1'b1; host_addr = a; host_wdata = 16'(d);
    @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_meas();
    m_sum = 0; m_sq = 0; m_cnt = 0; m_on = 1;
    host(1'b1, 0);
  endtask

  function automatic int sval(input int kind, input int t, input int s);
    if (kind == 1) return -777;
    if (kind == 2) return (t % 2 == 1) ? 8191 : -8192;
    return ((t * 73 + s * 29) % 3001) - 1500;
  endfunction

  // One turn: marker (idle or with sample 0), a gap after sample 1
  task automatic turn(input int nsamp, input bit idle_mark, input int kind);
    if (idle_mark) drive(0, 1111, 1);
    for (int s = 0; s < nsamp; s++) begin
      int v;
      v = sval(kind, turn_no, s);
      drive(1, v, (!idle_mark && s == 0));
      if (m_on && m_cnt < NT && s == cur_slot) begin
        m_sum += v; m_sq += longint'(v) * v; m_cnt++;
      end
      if (s == 1) drive(0, -4321, 0);
    end
    drive(0, 0, 0);
    turn_no++;
  endtask

  task automatic expect_result(input string req, input int done_before);
    longint em, ev;
    repeat (12) @(negedge clk);
    em = m_sum >>> LG;
    ev = (longint'(NT) * m_sq - m_sum * m_sum) >>> (2 * LG);
    check({req, " done count"}, done_cnt - done_before, 1);
    check({req, " busy low"}, busy, 0);
    check({req, " mean"}, longint'(mean), em);
    check({req, " variance"}, longint'(variance), ev);
    check("R5 done single cycle", dbl_done, 0);
    m_on = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 slot_err", slot_err, 0);
    check("R1 mean", longint'(mean), 0);
    check("R1 variance", longint'(variance), 0);
  endtask

  task automatic t_premarker();
    int d0;
    d0 = done_cnt;
    cur_slot = 0;
    start_meas();
    for (int i = 0; i < 20; i++) drive(1, 5000, 0);
    drive(0, 0, 0);
    check("R4 no capture before first marker", busy, 1);
    for (int i = 0; i < NT; i++) turn(SLOTS, 0, 0);
    expect_result("R4 slot0 marker with sample", d0);
  endtask

  task automatic t_basic();
    int d0;
    d0 = done_cnt;
    host(1'b0, 3); cur_slot = 3;
    check("R2 slot accepted", slot_err, 0);
    start_meas();
    check("R5 busy after start", busy, 1);
    for (int i = 0; i < NT - 1; i++) turn(SLOTS, 1, 0);
    repeat (6) @(negedge clk);
    check("R5 no done before last turn", done_cnt - d0, 0);
    turn(SLOTS, 1, 0);
    expect_result("R6 R7 slot3 idle marker", d0);
  endtask

  task automatic t_const();
    int d0;
    d0 = done_cnt;
    host(1'b0, SLOTS - 1); cur_slot = SLOTS - 1;
    start_meas();
    for (int i = 0; i < NT; i++) turn(SLOTS, i % 2 == 1, 1);
    expect_result("R7 constant bunch", d0);
    check("R7 zero spread", longint'(variance), 0);
    check("R6 negative mean", longint'(mean), -777);
  endtask

  task automatic t_bad_slot();
    int d0;
    d0 = done_cnt;
    host(1'b0, 5); cur_slot = 5;
    host(1'b0, SLOTS);
    check("R3 slot_err set", slot_err, 1);
    host(1'b0, 200);
    check("R3 slot_err still set", slot_err, 1);
    start_meas();
    for (int i = 0; i < NT; i++) turn(SLOTS, 0, 0);
    expect_result("R3 old slot kept", d0);
    host(1'b0, 2); cur_slot = 2;
    check("R2 slot_err cleared", slot_err, 0);
  endtask

  task automatic t_early_marker();
    int d0;
    d0 = done_cnt;
    host(1'b0, 6); cur_slot = 6;
    start_meas();
    for (int i = 0; i < 4; i++) turn(5, 0, 0);
    check("R8 unreached slot gives no done", done_cnt - d0, 0);
    check("R8 still busy", busy, 1);
    host(1'b0, 2); cur_slot = 2;
    for (int i = 0; i < NT; i++) turn(5, i % 2 == 0, 0);
    expect_result("R8 short turns", d0);
  endtask

  task automatic t_hold();
    longint hm, hv;
    int d0;
    hm = longint'(mean); hv = longint'(variance); d0 = done_cnt;
    host(1'b0, 1); cur_slot = 1;
    for (int i = 0; i < 3; i++) turn(SLOTS, 0, 2);
    check("R9 mean held", longint'(mean), hm);
    check("R9 variance held", longint'(variance), hv);
    check("R9 no done while idle", done_cnt - d0, 0);
  endtask

  task automatic t_restart();
    int d0;
    d0 = done_cnt;
    host(1'b0, 4); cur_slot = 4;
    start_meas();
    for (int i = 0; i < 3; i++) turn(SLOTS, 0, 1);
    start_meas();
    for (int i = 0; i < NT; i++) turn(SLOTS, 0, 0);
    expect_result("R10 restart discards partial", d0);
  endtask

  task automatic t_extreme();
    int d0;
    d0 = done_cnt;
    host(1'b0, 7); cur_slot = 7;
    start_meas();
    for (int i = 0; i < NT; i++) turn(SLOTS, 1, 2);
    expect_result("R6 R7 full-scale extremes", d0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_premarker();
    t_basic();
    t_const();
    t_bad_slot();
    t_early_marker();
    t_hold();
    t_restart();
    t_extreme();
    summary();
  end
endmodule